// File: doc/BRIEF.md
# Descriptor-Fetch Cycle-Steal DMA Engine

This block is the bus-master side of a synchronous serial adapter. Software gives it the address of an eight-word control block in memory using two byte-wide commands. The first command supplies the low byte. The second supplies the high byte and starts the engine. From then on the engine works without software help. It borrows memory cycles to read the whole control block, then moves data words. In receive direction, words arriving from the line side are written to memory. In transmit direction, words are read from memory and handed to the line side. When the transfer count runs out, the engine either follows the chain address to another control block or finishes.

All memory traffic uses one request/grant pair. The engine raises a request, keeps its address and direction steady, and moves exactly one 16-bit word in each cycle where request and grant are both high. The word count and data address are copied into internal registers, and the copies are counted down and up. The control block in memory is never written.

The sequencer has seven states, with these transitions:
- IDLE goes to FETCH on an accepted start.
- FETCH reads block words 0 to 7 and goes to DECIDE after the last grant.
- DECIDE goes back to FETCH when the count is zero and chaining is on. It goes to IDLE, raising the done pulse, when the count is zero and chaining is off. Otherwise it goes to RX_WAIT for receive or to TX_READ for transmit.
- RX_WAIT takes one line word and goes to RX_WRITE.
- RX_WRITE stores that word and returns to DECIDE on grant.
- TX_READ loads a word on grant and goes to TX_SEND.
- TX_SEND offers the word to the line side and returns to DECIDE once it is taken.

Top module: `cblk_dma_engine`

## Requirements
- R1: A command is accepted only when `cmd_dev` is 6'b001100 and `cmd_mod` is 6'b000000; any other command has no effect. An accepted command with `cmd_op` = 0 (address-low) while idle loads `cmd_data` into bits 7:0 of the block address.
- R2: An accepted command with `cmd_op` = 1 (initiate) while idle loads `cmd_data` into bits 15:8 of the block address. It raises `busy` on the next cycle, and fetching begins at the assembled address.
- R3: The fetch reads eight consecutive words, from block address +0 to +7, in ascending order. Word 3 is the control word: bit 0 = 1 selects receive, bit 0 = 0 selects transmit, and bit 1 = 1 enables chaining. Word 4 is the chain address, word 6 the word count and word 7 the data start address. Words 0, 1, 2 and 5 and all other control bits are ignored.
- R4: `mem_req` implies `busy`. While `mem_req` is high without `mem_gnt`, the request, `mem_addr` and `mem_we` hold on the next cycle. Exactly one word moves in each cycle where both are high.
- R5: In receive, each word taken on the line side (`rx_valid` and `rx_ready` both high) is written to memory at data start + n, for n = 0, 1, 2 and so on, in arrival order.
- R6: In transmit, word n is read from data start + n and then held on `tx_data` with `tx_valid` until `tx_ready`.
- R7: A block moves exactly as many words as its count. A count of 0 moves no data.
- R8: When the count is exhausted and the chaining bit is set, the next block is fetched at the chain address with no software action. Only the last block of a chain produces a done pulse.
- R9: The engine never writes to control-block words. Every memory write is a receive data write.
- R10: On finishing a block whose chaining bit is clear, `done` is high for exactly one cycle, and `busy` is low in that cycle.
- R11: While busy, an initiate is ignored and sets `cmd_reject`, and an address-low command is ignored. `cmd_reject` stays set until the next accepted initiate clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 2 | 0 = address-low, 1 = initiate |
| cmd_dev | input | 6 | Device select of the command |
| cmd_mod | input | 6 | Module select of the command |
| cmd_data | input | 8 | Address byte carried by the command |
| busy | output | 1 | Engine is working on a block or chain |
| done | output | 1 | One-cycle completion pulse |
| cmd_reject | output | 1 | Sticky flag: an initiate arrived while busy |
| mem_req | output | 1 | Memory cycle request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 16 | Write data |
| mem_gnt | input | 1 | Memory grant; a transfer happens when it and `mem_req` are both high |
| mem_rdata | input | 16 | Read data, valid in the granted cycle |
| rx_valid | input | 1 | Line side offers a received word |
| rx_data | input | 16 | Received word |
| rx_ready | output | 1 | Engine takes a received word |
| tx_valid | output | 1 | Engine offers a word to transmit |
| tx_data | output | 16 | Word to transmit |
| tx_ready | input | 1 | Line side takes the transmit word |

## Verification
The grant, line-side valid and ready lines stall in patterns that do not line up with one another. A design that moved a word on request alone, or that let its address drift during a stall, would add, drop or misplace scoreboard items. A chain that passes through a zero-count block exposes engines that move a word before testing the count, or that raise done at each block instead of only at the end of the chain. An initiate and an address-low command sent mid-transfer, followed by an initiate that supplies only a new high byte, would expose an engine that lets either busy-time command disturb the running block or the stored low byte. A command with a foreign device select, sent between the two real ones, would move the fetch address if the select were not checked.

// File: rtl/cblk_pkg.sv
package cblk_pkg;

    // Control block layout (word offsets inside the block)
    localparam int BLK_WORDS     = 8;
    localparam int IDX_W         = $clog2(BLK_WORDS);
    localparam int OFS_CTL       = 3;
    localparam int OFS_NEXT      = 4;
    localparam int OFS_COUNT     = 6;
    localparam int OFS_DSTART    = 7;

    // Control word bits
    localparam int CTL_RX_BIT    = 0;
    localparam int CTL_CHAIN_BIT = 1;

    typedef enum logic [1:0] {
        OP_ADDR_LO  = 2'd0,
        OP_INITIATE = 2'd1
    } cmd_op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_DECIDE,
        S_RX_WAIT,
        S_RX_WRITE,
        S_TX_READ,
        S_TX_SEND
    } seq_state_e;

endpackage

// File: rtl/cblk_addr_reg.sv
module cblk_addr_reg
    import cblk_pkg::*;
#(
    parameter int          W      = 16,
    parameter int          ID_W   = 6,
    parameter logic [5:0]  DEV_ID = 6'b001100,
    parameter logic [5:0]  MOD_ID = 6'b000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [ID_W-1:0]   cmd_dev,
    input  logic [ID_W-1:0]   cmd_mod,
    input  logic [W/2-1:0]    cmd_data,
    input  logic              busy,
    input  logic              chain_load,
    input  logic [W-1:0]      chain_addr,
    output logic [W-1:0]      base,
    output logic              start,
    output logic              reject
);
    localparam int HALF = W / 2;

    logic hit, lo_wr, init_cmd;
    logic [W-1:0] base_q;
    logic         reject_q;

    always_comb begin
        hit      = cmd_valid && (cmd_dev == DEV_ID[ID_W-1:0])
                             && (cmd_mod == MOD_ID[ID_W-1:0]);
        lo_wr    = hit && (cmd_op == OP_ADDR_LO) && !busy;
        init_cmd = hit && (cmd_op == OP_INITIATE);
        start    = init_cmd && !busy;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q   <= '0;
            reject_q <= 1'b0;
        end else begin
            if (chain_load) begin
                base_q <= chain_addr;
            end else begin
                if (lo_wr) base_q[HALF-1:0] <= cmd_data;
                if (start) base_q[W-1:HALF] <= cmd_data;
            end
            if (init_cmd) reject_q <= busy;
        end
    end

    assign base   = base_q;
    assign reject = reject_q;
endmodule

// File: rtl/cblk_xfer_ctr.sv
module cblk_xfer_ctr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld_cnt,
    input  logic         ld_addr,
    input  logic [W-1:0] din,
    input  logic         step,
    output logic [W-1:0] cur_addr,
    output logic         cnt_zero
);
    logic [W-1:0] cnt_q, addr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            addr_q <= '0;
        end else begin
            if (ld_cnt)       cnt_q <= din;
            else if (step)    cnt_q <= cnt_q - 1'b1;
            if (ld_addr)      addr_q <= din;
            else if (step)    addr_q <= addr_q + 1'b1;
        end
    end

    assign cur_addr = addr_q;
    assign cnt_zero = (cnt_q == '0);
endmodule

// File: rtl/cblk_seq.sv
module cblk_seq
    import cblk_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] base,
    input  logic [W-1:0] cur_addr,
    input  logic         cnt_zero,
    input  logic         mem_gnt,
    input  logic [W-1:0] mem_rdata,
    input  logic         rx_valid,
    input  logic [W-1:0] rx_data,
    input  logic         tx_ready,
    output logic         busy,
    output logic         done,
    output logic         chain_load,
    output logic [W-1:0] chain_addr,
    output logic         ld_cnt,
    output logic         ld_addr,
    output logic         step,
    output logic         mem_req,
    output logic         mem_we,
    output logic [W-1:0] mem_addr,
    output logic [W-1:0] mem_wdata,
    output logic         rx_ready,
    output logic         tx_valid,
    output logic [W-1:0] tx_data
);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(BLK_WORDS - 1);

    seq_state_e       state_q, state_d;
    logic [IDX_W-1:0] idx_q;
    logic             rx_dir_q, chain_q, done_q;
    logic [W-1:0]     next_q, hold_q;
    logic             fetch_beat;

    assign fetch_beat = (state_q == S_FETCH) && mem_gnt;

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:     if (start) state_d = S_FETCH;
            S_FETCH:    if (mem_gnt && idx_q == IDX_LAST) state_d = S_DECIDE;
            S_DECIDE: begin
                if (cnt_zero)      state_d = chain_q ? S_FETCH : S_IDLE;
                else if (rx_dir_q) state_d = S_RX_WAIT;
                else               state_d = S_TX_READ;
            end
            S_RX_WAIT:  if (rx_valid) state_d = S_RX_WRITE;
            S_RX_WRITE: if (mem_gnt)  state_d = S_DECIDE;
            S_TX_READ:  if (mem_gnt)  state_d = S_TX_SEND;
            S_TX_SEND:  if (tx_ready) state_d = S_DECIDE;
            default:    state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers owned by the sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q    <= '0;
            rx_dir_q <= 1'b0;
            chain_q  <= 1'b0;
            next_q   <= '0;
            hold_q   <= '0;
            done_q   <= 1'b0;
        end else begin
            if (state_q != S_FETCH) idx_q <= '0;
            else if (mem_gnt)       idx_q <= idx_q + 1'b1;
            if (fetch_beat && idx_q == IDX_W'(OFS_CTL)) begin
                rx_dir_q <= mem_rdata[CTL_RX_BIT];
                chain_q  <= mem_rdata[CTL_CHAIN_BIT];
            end
            if (fetch_beat && idx_q == IDX_W'(OFS_NEXT)) next_q <= mem_rdata;
            if (state_q == S_RX_WAIT && rx_valid)      hold_q <= rx_data;
            else if (state_q == S_TX_READ && mem_gnt)  hold_q <= mem_rdata;
            done_q <= (state_q == S_DECIDE) && cnt_zero && !chain_q;
        end
    end

    // outputs
    always_comb begin
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = cur_addr;
        mem_wdata  = '0;
        rx_ready   = 1'b0;
        tx_valid   = 1'b0;
        tx_data    = '0;
        chain_load = 1'b0;
        ld_cnt     = 1'b0;
        ld_addr    = 1'b0;
        step       = 1'b0;
        unique case (state_q)
            S_IDLE: ;
            S_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = base + W'(idx_q);
                ld_cnt   = mem_gnt && (idx_q == IDX_W'(OFS_COUNT));
                ld_addr  = mem_gnt && (idx_q == IDX_W'(OFS_DSTART));
            end
            S_DECIDE:   chain_load = cnt_zero && chain_q;
            S_RX_WAIT:  rx_ready = 1'b1;
            S_RX_WRITE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = hold_q;
                step      = mem_gnt;
            end
            S_TX_READ: begin
                mem_req = 1'b1;
                step    = mem_gnt;
            end
            S_TX_SEND: begin
                tx_valid = 1'b1;
                tx_data  = hold_q;
            end
            default: ;
        endcase
    end

    assign busy       = (state_q != S_IDLE);
    assign done       = done_q;
    assign chain_addr = next_q;
endmodule

// File: rtl/cblk_dma_engine.sv
module cblk_dma_engine
    import cblk_pkg::*;
#(
    parameter int          W      = 16,
    parameter int          ID_W   = 6,
    parameter logic [5:0]  DEV_ID = 6'b001100,
    parameter logic [5:0]  MOD_ID = 6'b000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [ID_W-1:0]   cmd_dev,
    input  logic [ID_W-1:0]   cmd_mod,
    input  logic [W/2-1:0]    cmd_data,
    output logic              busy,
    output logic              done,
    output logic              cmd_reject,
    output logic              mem_req,
    output logic              mem_we,
    output logic [W-1:0]      mem_addr,
    output logic [W-1:0]      mem_wdata,
    input  logic              mem_gnt,
    input  logic [W-1:0]      mem_rdata,
    input  logic              rx_valid,
    input  logic [W-1:0]      rx_data,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [W-1:0]      tx_data,
    input  logic              tx_ready
);
    logic         start, chain_load, ld_cnt, ld_addr, step, cnt_zero;
    logic [W-1:0] base, chain_addr, cur_addr;

    cblk_addr_reg #(.W(W), .ID_W(ID_W), .DEV_ID(DEV_ID), .MOD_ID(MOD_ID)) u_areg (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_dev(cmd_dev), .cmd_mod(cmd_mod), .cmd_data(cmd_data), .busy(busy),
        .chain_load(chain_load), .chain_addr(chain_addr), .base(base),
        .start(start), .reject(cmd_reject)
    );

    cblk_xfer_ctr #(.W(W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .ld_cnt(ld_cnt), .ld_addr(ld_addr),
        .din(mem_rdata), .step(step), .cur_addr(cur_addr), .cnt_zero(cnt_zero)
    );

    cblk_seq #(.W(W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .base(base), .cur_addr(cur_addr),
        .cnt_zero(cnt_zero), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .tx_ready(tx_ready),
        .busy(busy), .done(done), .chain_load(chain_load), .chain_addr(chain_addr),
        .ld_cnt(ld_cnt), .ld_addr(ld_addr), .step(step), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data)
    );
endmodule

// File: rtl/cblk_dma_checker.sv
module cblk_dma_checker #(
    parameter int          W      = 16,
    parameter int          ID_W   = 6,
    parameter logic [5:0]  DEV_ID = 6'b001100,
    parameter logic [5:0]  MOD_ID = 6'b000000
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cmd_valid,
    input logic [1:0]      cmd_op,
    input logic [ID_W-1:0] cmd_dev,
    input logic [ID_W-1:0] cmd_mod,
    input logic            busy,
    input logic            done,
    input logic            cmd_reject,
    input logic            mem_req,
    input logic            mem_we,
    input logic [W-1:0]    mem_addr,
    input logic            mem_gnt,
    input logic            tx_valid,
    input logic [W-1:0]    tx_data,
    input logic            tx_ready
);
    logic init_hit;
    assign init_hit = cmd_valid && (cmd_op == 2'd1)
                   && (cmd_dev == DEV_ID[ID_W-1:0]) && (cmd_mod == MOD_ID[ID_W-1:0]);

    assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        init_hit && !busy |=> busy);

    assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    assert_req_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    assert_tx_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

    assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_reject_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
        init_hit && busy |=> cmd_reject);
endmodule

bind cblk_dma_engine cblk_dma_checker #(
    .W(W), .ID_W(ID_W), .DEV_ID(DEV_ID), .MOD_ID(MOD_ID)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_dev(cmd_dev), .cmd_mod(cmd_mod), .busy(busy), .done(done),
    .cmd_reject(cmd_reject), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_gnt(mem_gnt), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_ready(tx_ready)
);

// File: tb/sim_cblk_dma_engine.sv
`timescale 1ns/1ps
module sim_cblk_dma_engine;
    localparam int EV_RD = 0, EV_WR = 1, EV_TX = 2;
    localparam logic [5:0] DEV = 6'b001100, MODL = 6'b000000;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = '0;
    logic [5:0]  cmd_dev = '0, cmd_mod = '0;
    logic [7:0]  cmd_data = '0;
    logic        busy, done, cmd_reject, mem_req, mem_we, rx_ready, tx_valid;
    logic [15:0] mem_addr, mem_wdata, tx_data, mem_rdata;
    logic        mem_gnt = 1'b0, rx_valid = 1'b0, tx_ready = 1'b0;
    logic [15:0] rx_data = '0;

    logic [15:0] mem [0:1023];
    logic        host_we = 1'b0;
    logic [9:0]  host_addr = '0;
    logic [15:0] host_data = '0;

    typedef struct {
        int          kind;
        logic [15:0] addr;
        logic [15:0] data;
        string       req;
    } ev_t;
    ev_t         exp_q[$];
    logic [15:0] rx_buf[$];

    int checks = 0, fails = 0, done_seen = 0, cyc = 0;

    cblk_dma_engine u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_dev(cmd_dev), .cmd_mod(cmd_mod), .cmd_data(cmd_data),
        .busy(busy), .done(done), .cmd_reject(cmd_reject),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready)
    );

    assign mem_rdata = mem[mem_addr[9:0]];

    always @(posedge clk) begin
        if (host_we) mem[host_addr] <= host_data;
        else if (mem_req && mem_gnt && mem_we) mem[mem_addr[9:0]] <= mem_wdata;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // monitor: new stimulus first, then the handshakes the next edge will see
    always @(negedge clk) begin
        ev_t e;
        cyc++;
        if (!rst_n) begin
            mem_gnt = 1'b0; rx_valid = 1'b0; tx_ready = 1'b0;
        end else begin
            mem_gnt  = (cyc % 3) != 0;
            tx_ready = (cyc % 4) != 1;
            rx_valid = (rx_buf.size() > 0) && ((cyc % 5) != 2);
            rx_data  = rx_valid ? rx_buf[0] : 16'h0;
            if (done) begin
                done_seen++;
                check(!busy, "R10", "busy during done", int'(busy), 0);
            end
            if (mem_req && mem_gnt) begin
                if (exp_q.size() == 0) begin
                    check(0, "R9", "unexpected memory cycle", int'(mem_addr), -1);
                end else begin
                    e = exp_q.pop_front();
                    check(e.kind == (mem_we ? EV_WR : EV_RD), e.req, "cycle kind",
                          mem_we ? EV_WR : EV_RD, e.kind);
                    check(e.addr == mem_addr, e.req, "memory address",
                          int'(mem_addr), int'(e.addr));
                    if (mem_we)
                        check(e.data == mem_wdata, e.req, "write data",
                              int'(mem_wdata), int'(e.data));
                end
            end
            if (tx_valid && tx_ready) begin
                if (exp_q.size() == 0) begin
                    check(0, "R6", "unexpected tx word", int'(tx_data), -1);
                end else begin
                    e = exp_q.pop_front();
                    check(e.kind == EV_TX, e.req, "tx kind", EV_TX, e.kind);
                    check(e.data == tx_data, e.req, "tx data",
                          int'(tx_data), int'(e.data));
                end
            end
            if (rx_valid && rx_ready) void'(rx_buf.pop_front());
        end
    end

    task automatic push(input int kind, input logic [15:0] a, input logic [15:0] d,
                        input string req);
        ev_t e;
        e.kind = kind; e.addr = a; e.data = d; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic host_wr(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a[9:0]; host_data = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic put_block(input logic [15:0] b, input logic [15:0] ctl,
                             input logic [15:0] nxt, input logic [15:0] cnt,
                             input logic [15:0] dst);
        host_wr(b + 0, 16'hDEAD); host_wr(b + 1, 16'hBEEF);
        host_wr(b + 2, 16'hFFFF); host_wr(b + 3, ctl);
        host_wr(b + 4, nxt);      host_wr(b + 5, 16'h5A5A);
        host_wr(b + 6, cnt);      host_wr(b + 7, dst);
    endtask

    task automatic push_fetch(input logic [15:0] b, input string req);
        for (int i = 0; i < 8; i++) push(EV_RD, b + 16'(i), 16'h0, req);
    endtask

    task automatic send(input logic [1:0] op, input logic [5:0] dev, input logic [7:0] d);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_dev = dev; cmd_mod = MODL; cmd_data = d;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int start_cnt = done_seen;
        int n = 0;
        while (done_seen == start_cnt && n < 3000) begin
            @(posedge clk);
            n++;
        end
        check(done_seen == start_cnt + 1, req, "done pulse seen", done_seen - start_cnt, 1);
        repeat (6) @(posedge clk);
        check(done_seen == start_cnt + 1, req, "done pulse count", done_seen - start_cnt, 1);
        check(!busy, req, "busy after done", int'(busy), 0);
        check(exp_q.size() == 0, "R7", "leftover expected items", exp_q.size(), 0);
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        check(0, "all", "watchdog expired", cyc, 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) mem[i] = 16'h0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !cmd_reject, "R10", "reset outputs",
              {busy, done, cmd_reject}, 0);
        check(!mem_req && !tx_valid && !rx_ready, "R4", "reset handshakes",
              {mem_req, tx_valid, rx_ready}, 0);

        // receive, count 3; a foreign-device command between the two real ones (R1)
        put_block(16'h0120, 16'h0001, 16'h0000, 16'd3, 16'h0200);
        push_fetch(16'h0120, "R1");
        for (int i = 0; i < 3; i++) begin
            rx_buf.push_back(16'hA001 + 16'(i));
            push(EV_WR, 16'h0200 + 16'(i), 16'hA001 + 16'(i), "R5");
        end
        send(2'd0, DEV, 8'h20);
        send(2'd0, 6'b000001, 8'hEE);
        send(2'd1, 6'b000011, 8'h07);
        check(!busy, "R1", "foreign initiate started engine", int'(busy), 0);
        send(2'd1, DEV, 8'h01);
        check(busy, "R2", "busy after initiate", int'(busy), 1);
        wait_done("R10");

        // transmit, count 4, with busy-time commands (R11)
        for (int i = 0; i < 4; i++) host_wr(16'h0240 + 16'(i), 16'hC300 + 16'(i * 7));
        put_block(16'h0140, 16'h0000, 16'h0000, 16'd4, 16'h0240);
        push_fetch(16'h0140, "R3");
        for (int i = 0; i < 4; i++) begin
            push(EV_RD, 16'h0240 + 16'(i), 16'h0, "R6");
            push(EV_TX, 16'h0, 16'hC300 + 16'(i * 7), "R6");
        end
        send(2'd0, DEV, 8'h40);
        send(2'd1, DEV, 8'h01);
        repeat (4) @(negedge clk);
        check(busy, "R11", "busy before early initiate", int'(busy), 1);
        send(2'd1, DEV, 8'h03);
        check(cmd_reject, "R11", "reject after busy initiate", int'(cmd_reject), 1);
        send(2'd0, DEV, 8'h99);
        wait_done("R6");
        check(cmd_reject, "R11", "reject stays set", int'(cmd_reject), 1);
        check(mem[16'h0146] == 16'd4, "R9", "count word in memory", int'(mem[16'h0146]), 4);
        check(mem[16'h0147] == 16'h0240, "R9", "start word in memory",
              int'(mem[16'h0147]), 16'h0240);

        // zero count; only the high byte is sent, so the kept low byte 0x40 must be used
        put_block(16'h0340, 16'h0000, 16'h0000, 16'd0, 16'h0300);
        push_fetch(16'h0340, "R11");
        send(2'd1, DEV, 8'h03);
        check(!cmd_reject, "R11", "reject cleared by accepted initiate", int'(cmd_reject), 0);
        wait_done("R7");

        // chain: receive 2 -> zero-count block -> transmit 2 (R8)
        put_block(16'h0160, 16'h0003, 16'h01A0, 16'd2, 16'h0280);
        put_block(16'h01A0, 16'h0002, 16'h0180, 16'd0, 16'h0000);
        put_block(16'h0180, 16'h0000, 16'h0000, 16'd2, 16'h02C0);
        host_wr(16'h02C0, 16'h1234); host_wr(16'h02C1, 16'h8765);
        push_fetch(16'h0160, "R8");
        for (int i = 0; i < 2; i++) begin
            rx_buf.push_back(16'h7E10 + 16'(i));
            push(EV_WR, 16'h0280 + 16'(i), 16'h7E10 + 16'(i), "R5");
        end
        push_fetch(16'h01A0, "R8");
        push_fetch(16'h0180, "R8");
        push(EV_RD, 16'h02C0, 16'h0, "R8");
        push(EV_TX, 16'h0, 16'h1234, "R8");
        push(EV_RD, 16'h02C1, 16'h0, "R8");
        push(EV_TX, 16'h0, 16'h8765, "R8");
        send(2'd0, DEV, 8'h60);
        send(2'd1, DEV, 8'h01);
        wait_done("R8");
        check(mem[16'h0281] == 16'h7E11, "R5", "last received word stored",
              int'(mem[16'h0281]), 16'h7E11);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule